// File: doc/BRIEF.md
# Byte-Order-Selectable Data Buffer Port

This block sits between a 16-bit host data register and a small transfer holding buffer of four bytes. It accepts 16-bit host writes, which add two bytes to the buffer, and 8-bit host writes, which add one byte. It also accepts 16-bit host reads, which take up to two bytes out of the buffer. A byte-order input is sampled on every access. It decides which half of the 16-bit word maps to which buffer byte. One fill counter covers both directions. A bus sequencer outside the block appends received bytes and removes bytes to transmit through a simple push/pop side port.

Each accepted access produces one-cycle pulses for the neighbouring status logic, and each of them asks the sequencer to run. A write clears transmit-ready and transmit-underflow. A read clears receive-ready and receive-overrun. A read that finds a single byte raises a single-byte status request. A read made while in master receive sets access-ready and drops master mode. An 8-bit write closes the transfer: the buffer takes no more host writes until it has drained completely.

Top module: `dbp_port`

## Requirements
- R1: After synchronous reset the fill level is 0 and tx_valid is low. rd_data reads 0x0000 and every pulse output is low.
- R2: An accepted 16-bit write adds 2 to the fill level. With big_endian=1, wr_data[15:8] becomes buffer byte 1 and wr_data[7:0] becomes byte 0. With big_endian=0 the two halves swap. Byte 1 of the new pair leaves on the transmit side before byte 0.
- R3: An 8-bit write (wr_narrow=1) is accepted while the fill level is below 4. It appends wr_data[7:0] as the newest byte and adds 1 to the fill level. After it, every host write is ignored until the fill level returns to 0.
- R4: A 16-bit write is ignored when the fill level exceeds 2, and an 8-bit write is ignored when the level is 4. An ignored write changes no byte and raises no pulse.
- R5: In the cycle after an accepted write, clr_tx_ready, clr_tx_underflow and run_req are high for exactly one cycle.
- R6: A read takes the two oldest bytes, b0 (oldest) then b1. The next cycle rd_data holds {b0,b1} when big_endian=1 and {b1,b0} when big_endian=0. The fill level drops by 2 and the remaining bytes move down.
- R7: A read that finds exactly one byte returns it in the half that b0 would use, with zero in the other half. It empties the buffer and pulses single_byte_set the next cycle.
- R8: A read of an empty buffer returns 0x0000 and leaves the fill level at 0, and single_byte_set stays low.
- R9: Every read, empty or not, pulses clr_rx_ready, clr_rx_overrun and run_req in the next cycle.
- R10: A read made while master_mode=1 and receive_mode=1 pulses access_ready_set and master_clear in the next cycle. Otherwise both stay low.
- R11: rx_push appends rx_byte as the newest byte when the fill level is below 4 and is ignored when it is 4.
- R12: tx_byte shows the newest-but-unsent byte (index fill-1) and tx_valid is high whenever the fill level is nonzero. tx_pop removes that byte, and tx_pop on an empty buffer is ignored.
- R13: Only one operation takes effect per cycle. A write request wins over a read, a read over rx_push, and rx_push over tx_pop. The losing requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_endian | input | 1 | Byte order for the current access (1 = high half is byte 0 on read) |
| wr_en | input | 1 | Host data write request |
| wr_narrow | input | 1 | Write is 8-bit (final byte) |
| wr_data | input | 16 | Host write data |
| rd_en | input | 1 | Host data read request |
| rd_data | output | 16 | Registered host read data |
| master_mode | input | 1 | Controller is bus master |
| receive_mode | input | 1 | Controller is receiving |
| rx_push | input | 1 | Sequencer appends a received byte |
| rx_byte | input | 8 | Received byte |
| tx_pop | input | 1 | Sequencer takes the next byte to send |
| tx_byte | output | 8 | Next byte to send |
| tx_valid | output | 1 | Buffer holds at least one byte |
| fill_level | output | $clog2(DEPTH+1) | Bytes held |
| clr_tx_ready | output | 1 | Pulse: clear transmit-ready |
| clr_tx_underflow | output | 1 | Pulse: clear transmit-underflow |
| clr_rx_ready | output | 1 | Pulse: clear receive-ready |
| clr_rx_overrun | output | 1 | Pulse: clear receive-overrun |
| single_byte_set | output | 1 | Pulse: set single-byte-data status |
| access_ready_set | output | 1 | Pulse: set access-ready |
| master_clear | output | 1 | Pulse: leave master mode |
| run_req | output | 1 | Pulse: ask the sequencer to run |

## Verification
A fill counter that drifts from the true byte count shows up at once on fill_level and tx_valid. Within a few pops it also shows up on tx_byte, as a repeated byte or a zero byte. A swapped byte lane or a wrong shift after a read shows in the very next rd_data or in the transmit order of the following pops. A stuck closed flag shows as writes that are refused, with no clear pulses, one cycle after the write.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_WR16 = 3'd1,
        OP_WR8  = 3'd2,
        OP_RD   = 3'd3,
        OP_PUSH = 3'd4,
        OP_POP  = 3'd5
    } op_e;

    typedef struct packed {
        byte_t upper;   // becomes buffer byte 1
        byte_t lower;   // becomes buffer byte 0
    } pair_t;

    function automatic pair_t split_write(input logic be, input word_t w);
        pair_t p;
        if (be) begin
            p.upper = w[15:8];
            p.lower = w[7:0];
        end else begin
            p.upper = w[7:0];
            p.lower = w[15:8];
        end
        return p;
    endfunction

    function automatic word_t join_read(input logic be, input byte_t b0, input byte_t b1);
        return be ? {b0, b1} : {b1, b0};
    endfunction
endpackage

// File: rtl/dbp_decode.sv
module dbp_decode
    import dbp_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              wr_en,
    input  logic              wr_narrow,
    input  logic              rd_en,
    input  logic              rx_push,
    input  logic              tx_pop,
    input  logic [FILL_W-1:0] fill,
    input  logic              closed,
    output op_e               op
);
    localparam logic [FILL_W-1:0] LIM16 = FILL_W'(DEPTH - 2);
    localparam logic [FILL_W-1:0] FULL  = FILL_W'(DEPTH);

    always_comb begin
        op = OP_IDLE;
        if (wr_en) begin
            if (!closed) begin
                if (wr_narrow) op = (fill < FULL) ? OP_WR8 : OP_IDLE;
                else           op = (fill <= LIM16) ? OP_WR16 : OP_IDLE;
            end
        end else if (rd_en) begin
            op = OP_RD;
        end else if (rx_push) begin
            op = (fill < FULL) ? OP_PUSH : OP_IDLE;
        end else if (tx_pop) begin
            op = (fill != '0) ? OP_POP : OP_IDLE;
        end
    end
endmodule

// File: rtl/dbp_store.sv
module dbp_store
    import dbp_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int FILL_W = $clog2(DEPTH + 1),
    localparam int MEM_W  = DEPTH * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  pair_t             wpair,
    input  byte_t             wbyte,
    input  byte_t             rx_byte,
    output byte_t             rd_b0,
    output byte_t             rd_b1,
    output byte_t             tx_top,
    output logic [FILL_W-1:0] fill,
    output logic              closed
);
    logic [MEM_W-1:0]  mem_q, mem_d;
    logic [FILL_W-1:0] fill_d;
    logic              closed_d;
    logic [FILL_W-1:0] take;
    logic [FILL_W-1:0] fill_m1;

    assign take    = (fill >= FILL_W'(2)) ? FILL_W'(2) : fill;
    assign fill_m1 = fill - FILL_W'(1);

    assign rd_b0  = (fill >= FILL_W'(1)) ? mem_q[BYTE_W-1:0] : '0;
    assign rd_b1  = (fill >= FILL_W'(2)) ? mem_q[2*BYTE_W-1:BYTE_W] : '0;
    assign tx_top = (fill != '0) ? byte_t'(mem_q >> {fill_m1, 3'b000}) : '0;

    always_comb begin
        mem_d  = mem_q;
        fill_d = fill;
        unique case (op)
            OP_WR16: begin
                mem_d  = (mem_q << (2 * BYTE_W)) | MEM_W'({wpair.upper, wpair.lower});
                fill_d = fill + FILL_W'(2);
            end
            OP_WR8: begin
                mem_d  = (mem_q << BYTE_W) | MEM_W'(wbyte);
                fill_d = fill + FILL_W'(1);
            end
            OP_RD: begin
                mem_d  = mem_q >> {take, 3'b000};
                fill_d = fill - take;
            end
            OP_PUSH: begin
                mem_d  = mem_q | (MEM_W'(rx_byte) << {fill, 3'b000});
                fill_d = fill + FILL_W'(1);
            end
            OP_POP: begin
                mem_d  = mem_q & ~(MEM_W'({BYTE_W{1'b1}}) << {fill_m1, 3'b000});
                fill_d = fill_m1;
            end
            default: ;
        endcase
        if (op == OP_WR8)         closed_d = 1'b1;
        else if (fill_d == '0)    closed_d = 1'b0;
        else                      closed_d = closed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q  <= '0;
            fill   <= '0;
            closed <= 1'b0;
        end else begin
            mem_q  <= mem_d;
            fill   <= fill_d;
            closed <= closed_d;
        end
    end

    // R11: the counter never passes the buffer depth
    a_r11_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill <= FILL_W'(DEPTH));
    // R2: a taken 16-bit write grows the level by two
    a_r2_wr16_grows: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WR16) |=> (fill == $past(fill) + FILL_W'(2)));
    // R3: the transfer stays closed only while bytes remain
    a_r3_closed_nonempty: assert property (@(posedge clk) disable iff (rst)
        closed |-> (fill != '0));
    // R8: reading an empty buffer keeps it empty
    a_r8_empty_read_keeps: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RD && fill == '0) |=> (fill == '0));
endmodule

// File: rtl/dbp_resp.sv
module dbp_resp
    import dbp_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic              big_endian,
    input  logic              master_mode,
    input  logic              receive_mode,
    input  logic [FILL_W-1:0] fill,
    input  byte_t             rd_b0,
    input  byte_t             rd_b1,
    output word_t             rd_data,
    output logic              clr_tx_ready,
    output logic              clr_tx_underflow,
    output logic              clr_rx_ready,
    output logic              clr_rx_overrun,
    output logic              single_byte_set,
    output logic              access_ready_set,
    output logic              master_clear,
    output logic              run_req
);
    logic is_wr, is_rd, mrx;

    assign is_wr = (op == OP_WR16) || (op == OP_WR8);
    assign is_rd = (op == OP_RD);
    assign mrx   = master_mode && receive_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data          <= '0;
            clr_tx_ready     <= 1'b0;
            clr_tx_underflow <= 1'b0;
            clr_rx_ready     <= 1'b0;
            clr_rx_overrun   <= 1'b0;
            single_byte_set  <= 1'b0;
            access_ready_set <= 1'b0;
            master_clear     <= 1'b0;
            run_req          <= 1'b0;
        end else begin
            if (is_rd) rd_data <= join_read(big_endian, rd_b0, rd_b1);
            clr_tx_ready     <= is_wr;
            clr_tx_underflow <= is_wr;
            clr_rx_ready     <= is_rd;
            clr_rx_overrun   <= is_rd;
            single_byte_set  <= is_rd && (fill == FILL_W'(1));
            access_ready_set <= is_rd && mrx;
            master_clear     <= is_rd && mrx;
            run_req          <= is_wr || is_rd;
        end
    end

    // R7: single-byte status only after a one-byte read
    a_r7_single_cause: assert property (@(posedge clk) disable iff (rst)
        single_byte_set |-> $past(fill == FILL_W'(1) && op == OP_RD));
    // R10: access-ready only from a read in master receive
    a_r10_mrx_cause: assert property (@(posedge clk) disable iff (rst)
        access_ready_set |-> $past(master_mode && receive_mode));
    // R8: empty read yields zero data
    a_r8_empty_zero: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RD && fill == '0) |=> (rd_data == '0));
    // R5: run request only follows a taken access
    a_r5_run_cause: assert property (@(posedge clk) disable iff (rst)
        run_req |-> $past(op == OP_WR16 || op == OP_WR8 || op == OP_RD));
endmodule

// File: rtl/dbp_port.sv
module dbp_port
    import dbp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       big_endian,
    input  logic                       wr_en,
    input  logic                       wr_narrow,
    input  logic [15:0]                wr_data,
    input  logic                       rd_en,
    output logic [15:0]                rd_data,
    input  logic                       master_mode,
    input  logic                       receive_mode,
    input  logic                       rx_push,
    input  logic [7:0]                 rx_byte,
    input  logic                       tx_pop,
    output logic [7:0]                 tx_byte,
    output logic                       tx_valid,
    output logic [$clog2(DEPTH+1)-1:0] fill_level,
    output logic                       clr_tx_ready,
    output logic                       clr_tx_underflow,
    output logic                       clr_rx_ready,
    output logic                       clr_rx_overrun,
    output logic                       single_byte_set,
    output logic                       access_ready_set,
    output logic                       master_clear,
    output logic                       run_req
);
    localparam int FILL_W = $clog2(DEPTH + 1);

    op_e               op;
    pair_t             wpair;
    byte_t             b0, b1;
    logic [FILL_W-1:0] fill;
    logic              closed;

    assign wpair      = split_write(big_endian, wr_data);
    assign fill_level = fill;
    assign tx_valid   = (fill != '0);

    dbp_decode #(.DEPTH(DEPTH)) u_decode (
        .wr_en(wr_en), .wr_narrow(wr_narrow), .rd_en(rd_en),
        .rx_push(rx_push), .tx_pop(tx_pop),
        .fill(fill), .closed(closed), .op(op)
    );

    dbp_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .op(op), .wpair(wpair), .wbyte(wr_data[7:0]),
        .rx_byte(rx_byte), .rd_b0(b0), .rd_b1(b1), .tx_top(tx_byte),
        .fill(fill), .closed(closed)
    );

    dbp_resp #(.DEPTH(DEPTH)) u_resp (
        .clk(clk), .rst(rst), .op(op), .big_endian(big_endian),
        .master_mode(master_mode), .receive_mode(receive_mode),
        .fill(fill), .rd_b0(b0), .rd_b1(b1), .rd_data(rd_data),
        .clr_tx_ready(clr_tx_ready), .clr_tx_underflow(clr_tx_underflow),
        .clr_rx_ready(clr_rx_ready), .clr_rx_overrun(clr_rx_overrun),
        .single_byte_set(single_byte_set), .access_ready_set(access_ready_set),
        .master_clear(master_clear), .run_req(run_req)
    );

    // R12: a valid transmit byte exists exactly when the level is nonzero
    a_r12_valid_level: assert property (@(posedge clk) disable iff (rst)
        (op == OP_POP) |-> tx_valid);
    // R13: a write request blocks any read pulse in the next cycle
    a_r13_write_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en) |=> !clr_rx_ready);
endmodule

// File: tb/test_dbp_port.sv
module test_dbp_port;
    logic        clk = 1'b0;
    logic        rst;
    logic        big_endian, wr_en, wr_narrow, rd_en;
    logic [15:0] wr_data, rd_data;
    logic        master_mode, receive_mode, rx_push, tx_pop;
    logic [7:0]  rx_byte, tx_byte;
    logic        tx_valid;
    logic [2:0]  fill_level;
    logic        clr_tx_ready, clr_tx_underflow, clr_rx_ready, clr_rx_overrun;
    logic        single_byte_set, access_ready_set, master_clear, run_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbp_port #(.DEPTH(4)) i_dbp_port (
        .clk(clk), .rst(rst), .big_endian(big_endian), .wr_en(wr_en),
        .wr_narrow(wr_narrow), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .master_mode(master_mode), .receive_mode(receive_mode),
        .rx_push(rx_push), .rx_byte(rx_byte), .tx_pop(tx_pop), .tx_byte(tx_byte),
        .tx_valid(tx_valid), .fill_level(fill_level),
        .clr_tx_ready(clr_tx_ready), .clr_tx_underflow(clr_tx_underflow),
        .clr_rx_ready(clr_rx_ready), .clr_rx_overrun(clr_rx_overrun),
        .single_byte_set(single_byte_set), .access_ready_set(access_ready_set),
        .master_clear(master_clear), .run_req(run_req)
    );

    typedef struct packed {
        logic        is_read;
        logic        be;
        logic [15:0] data;
        logic [15:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b1, 16'h1234, 16'h1234},
        '{1'b0, 1'b0, 16'h1234, 16'h3412},
        '{1'b0, 1'b1, 16'hA55A, 16'hA55A},
        '{1'b0, 1'b0, 16'h0F0E, 16'h0E0F},
        '{1'b1, 1'b1, 16'hABCD, 16'hABCD},
        '{1'b1, 1'b0, 16'hABCD, 16'hCDAB},
        '{1'b1, 1'b1, 16'h0102, 16'h0102},
        '{1'b1, 1'b0, 16'h8001, 16'h0180}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 0; wr_narrow = 0; rd_en = 0; rx_push = 0; tx_pop = 0;
    endtask

    task automatic do_wr(input logic be, input logic narrow, input logic [15:0] d);
        big_endian = be; wr_en = 1; wr_narrow = narrow; wr_data = d;
        @(negedge clk); idle_inputs();
    endtask

    task automatic do_rd(input logic be);
        big_endian = be; rd_en = 1;
        @(negedge clk); idle_inputs();
    endtask

    task automatic do_push(input logic [7:0] b);
        rx_push = 1; rx_byte = b;
        @(negedge clk); idle_inputs();
    endtask

    task automatic pop_chk(input string tag, input logic [7:0] exp);
        chk(tag, {8'h00, tx_byte}, {8'h00, exp});
        tx_pop = 1;
        @(negedge clk); idle_inputs();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1; big_endian = 1; wr_data = 0; rx_byte = 0;
        master_mode = 0; receive_mode = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk("R1 fill", {13'd0, fill_level}, 16'd0);
        chk("R1 valid", {15'd0, tx_valid}, 16'd0);
        chk("R1 rd_data", rd_data, 16'h0000);
        chk("R1 pulses", {8'd0, clr_tx_ready, clr_tx_underflow, clr_rx_ready, clr_rx_overrun,
            single_byte_set, access_ready_set, master_clear, run_req}, 16'd0);

        // table walk: R2/R5 writes, R6/R9 reads
        for (int i = 0; i < 8; i++) begin
            if (!VECS[i].is_read) begin
                do_wr(VECS[i].be, 1'b0, VECS[i].data);
                chk("R2 fill+2", {13'd0, fill_level}, 16'd2);
                chk("R5 pulses", {13'd0, clr_tx_ready, clr_tx_underflow, run_req}, 16'h0007);
                pop_chk("R2 first byte", VECS[i].exp[15:8]);
                chk("R5 one-cycle", {15'd0, run_req}, 16'd0);
                pop_chk("R2 second byte", VECS[i].exp[7:0]);
            end else begin
                do_push(VECS[i].data[15:8]);
                do_push(VECS[i].data[7:0]);
                do_rd(VECS[i].be);
                chk("R6 rd_data", rd_data, VECS[i].exp);
                chk("R6 fill", {13'd0, fill_level}, 16'd0);
                chk("R9 pulses", {13'd0, clr_rx_ready, clr_rx_overrun, run_req}, 16'h0007);
                chk("R10 no master", {14'd0, access_ready_set, master_clear}, 16'd0);
            end
        end

        // R3 narrow write closes the transfer
        do_wr(1'b1, 1'b0, 16'h1122);
        do_wr(1'b1, 1'b1, 16'hFF33);
        chk("R3 narrow fill", {13'd0, fill_level}, 16'd3);
        do_wr(1'b1, 1'b1, 16'h0066);
        chk("R3 closed fill", {13'd0, fill_level}, 16'd3);
        chk("R3 closed no pulse", {15'd0, clr_tx_ready}, 16'd0);
        pop_chk("R3 pop1", 8'h11);
        pop_chk("R3 pop2", 8'h22);
        pop_chk("R3 pop3", 8'h33);
        chk("R12 empty valid", {15'd0, tx_valid}, 16'd0);
        do_wr(1'b1, 1'b0, 16'h7788);
        chk("R3 reopened", {13'd0, fill_level}, 16'd2);
        pop_chk("R3 reopen pop1", 8'h77);
        pop_chk("R3 reopen pop2", 8'h88);

        // R4 no room
        do_wr(1'b1, 1'b0, 16'h0102);
        do_wr(1'b1, 1'b0, 16'h0304);
        chk("R4 full", {13'd0, fill_level}, 16'd4);
        do_wr(1'b1, 1'b0, 16'hEEEE);
        chk("R4 wide rejected", {13'd0, fill_level}, 16'd4);
        chk("R4 no pulse", {14'd0, clr_tx_ready, run_req}, 16'd0);
        do_wr(1'b1, 1'b1, 16'h00EE);
        chk("R4 narrow rejected", {13'd0, fill_level}, 16'd4);
        pop_chk("R4 pop1", 8'h01);
        pop_chk("R4 pop2", 8'h02);
        do_wr(1'b1, 1'b1, 16'h0099);
        chk("R4 narrow at 2", {13'd0, fill_level}, 16'd3);
        do_wr(1'b1, 1'b0, 16'h5555);
        chk("R4 wide at 3 rejected", {13'd0, fill_level}, 16'd3);
        pop_chk("R4 pop3", 8'h03);
        pop_chk("R4 pop4", 8'h04);
        pop_chk("R4 pop5", 8'h99);

        // R7 single byte read, both orders
        do_push(8'h5A);
        do_rd(1'b1);
        chk("R7 be data", rd_data, 16'h5A00);
        chk("R7 single pulse", {15'd0, single_byte_set}, 16'd1);
        chk("R7 empty", {13'd0, fill_level}, 16'd0);
        do_push(8'h5A);
        do_rd(1'b0);
        chk("R7 le data", rd_data, 16'h005A);

        // R8 empty read, R9 still pulses
        do_rd(1'b1);
        chk("R8 data", rd_data, 16'h0000);
        chk("R8 fill", {13'd0, fill_level}, 16'd0);
        chk("R8 no single", {15'd0, single_byte_set}, 16'd0);
        chk("R9 empty read pulses", {14'd0, clr_rx_ready, clr_rx_overrun}, 16'h0003);

        // R6 shift down after partial read
        do_push(8'h10); do_push(8'h20); do_push(8'h30);
        do_rd(1'b1);
        chk("R6 first pair", rd_data, 16'h1020);
        chk("R6 remaining", {13'd0, fill_level}, 16'd1);
        do_rd(1'b1);
        chk("R6 shifted byte", rd_data, 16'h3000);
        chk("R7 after shift", {15'd0, single_byte_set}, 16'd1);

        // R10 master receive
        master_mode = 1; receive_mode = 1;
        do_rd(1'b1);
        chk("R10 mrx pulses", {14'd0, access_ready_set, master_clear}, 16'h0003);
        receive_mode = 0;
        do_rd(1'b1);
        chk("R10 master tx none", {14'd0, access_ready_set, master_clear}, 16'd0);
        master_mode = 0;

        // R11 push when full dropped
        do_push(8'hA1); do_push(8'hA2); do_push(8'hA3); do_push(8'hA4); do_push(8'hA5);
        chk("R11 capped", {13'd0, fill_level}, 16'd4);
        do_rd(1'b1);
        chk("R11 pair1", rd_data, 16'hA1A2);
        do_rd(1'b1);
        chk("R11 pair2", rd_data, 16'hA3A4);
        chk("R11 drained", {13'd0, fill_level}, 16'd0);

        // R12 pop on empty ignored
        tx_pop = 1; @(negedge clk); idle_inputs();
        chk("R12 empty pop", {13'd0, fill_level}, 16'd0);

        // R13 priority
        do_push(8'hAA); do_push(8'hBB);
        big_endian = 1; wr_en = 1; wr_data = 16'h1122; rd_en = 1;
        @(negedge clk); idle_inputs();
        chk("R13 write wins fill", {13'd0, fill_level}, 16'd4);
        chk("R13 read ignored", {15'd0, clr_rx_ready}, 16'd0);
        rd_en = 1; rx_push = 1; rx_byte = 8'hEE; big_endian = 1;
        @(negedge clk); idle_inputs();
        chk("R13 read wins data", rd_data, 16'h2211);
        chk("R13 push ignored", {13'd0, fill_level}, 16'd2);
        rx_push = 1; rx_byte = 8'hCC; tx_pop = 1;
        @(negedge clk); idle_inputs();
        chk("R13 push wins", {13'd0, fill_level}, 16'd3);
        pop_chk("R13 pop1", 8'hCC);
        pop_chk("R13 pop2", 8'hBB);
        pop_chk("R13 pop3", 8'hAA);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule